// File: doc/BRIEF.md
# Tower-Field Byte Substitution Unit

This block performs the forward byte substitution of the AES cipher on one byte at a time. It is purely combinational: an 8-bit value enters and the substituted 8-bit value leaves, with no clock, reset or stored table. It is meant to sit inside a byte-serial encryption datapath, where one byte is substituted on each evaluation.

The datapath has no 256-entry lookup. The input byte is moved by a linear basis change into a three-level tower representation. Two-bit symbols form four-bit symbols, and four-bit symbols form the byte. The multiplicative inverse is found there using only small subfield multipliers, squarers and a four-bit inverter. A second linear map returns the result to the standard polynomial basis, and the cipher's affine step follows.

The basis-change matrices are derived at elaboration from the chosen subfield constants, so both admissible four-bit extension constants give a working unit. A parameter selects whether the return map and the affine step are fused into one matrix or kept as two stages.

Top module: `aes_tower_sbox`

## Requirements
- R1: For every one of the 256 input values, `sbox_out` equals the AES forward substitution of `sbox_in`. The reference is the inverse modulo x^8+x^4+x^3+x+1, followed by XOR of the value with its left rotations by 1, 2, 3 and 4 bits and the constant 0x63.
- R2: Input 0x00 gives output 0x63, because zero is treated as its own inverse.
- R3: Input 0x01 gives 0x7C, and input 0x53 gives 0xED.
- R4: Inside the four-bit inverter, a nonzero operand times its result is 1 in the four-bit tower field, and a zero operand yields zero.
- R5: Inside the byte inverter, a nonzero tower operand times its result is 1 in the eight-bit tower field, and a zero operand yields zero.
- R6: Applying the return basis map to the tower form of the input gives the input byte back.
- R7: The fused variant (MERGE_AFFINE=1) and the two-stage variant (MERGE_AFFINE=0) give identical outputs for every input.
- R8: The four-bit extension constant N_SEL may be 2 or 3, and both values give the correct substitution. Any other value stops elaboration.
- R9: The output follows a change of input with no clock edge in between, and holds no state from the previous input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sbox_in | input | 8 | Byte to substitute, standard polynomial basis |
| sbox_out | output | 8 | Substituted byte |

## Verification
Two functions can act on the same evaluation: the field inversion and the affine step with its constant. For input zero the inversion contributes nothing, and the constant alone must appear. For input one the inversion is the identity, and the affine matrix shows through unchanged. A new input is presented on every cycle, so consecutive values with unrelated inverses follow each other directly. Each result is judged against a reference computed by brute-force exponentiation in the standard basis. That reference is compared with two differently parameterised instances at once.

// File: rtl/aes_tower_pkg.sv
package aes_tower_pkg;

   typedef logic [7:0][7:0] map_t;   // map_t[i] = image of basis bit i

   function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
      logic [1:0] r;
      r[1] = (a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]);
      r[0] = (a[1] & b[1]) ^ (a[0] & b[0]);
      return r;
   endfunction

   function automatic logic [1:0] gf4_sq(input logic [1:0] a);
      return {a[1], a[1] ^ a[0]};
   endfunction

   function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b,
                                           input logic [1:0] n);
      logic [1:0] hh;
      hh = gf4_mul(a[3:2], b[3:2]);
      return {hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]),
              gf4_mul(hh, n) ^ gf4_mul(a[1:0], b[1:0])};
   endfunction

   function automatic logic [7:0] tw_mul(input logic [7:0] a, input logic [7:0] b,
                                         input logic [1:0] n, input logic [3:0] l);
      logic [3:0] hh;
      hh = gf16_mul(a[7:4], b[7:4], n);
      return {hh ^ gf16_mul(a[7:4], b[3:0], n) ^ gf16_mul(a[3:0], b[7:4], n),
              gf16_mul(hh, l, n) ^ gf16_mul(a[3:0], b[3:0], n)};
   endfunction

   // pick an L making Y^2+Y+L irreducible over the four-bit field
   function automatic logic [3:0] find_ext_const(input logic [1:0] n);
      logic [3:0] res;
      res = '0;
      for (int l = 15; l >= 1; l--) begin
         logic has_root;
         has_root = 1'b0;
         for (int x = 0; x < 16; x++) begin
            if ((gf16_mul(4'(x), 4'(x), n) ^ 4'(x) ^ 4'(l)) == 4'h0) has_root = 1'b1;
         end
         if (!has_root) res = 4'(l);
      end
      return res;
   endfunction

   function automatic logic [7:0] apply_map(input map_t m, input logic [7:0] x);
      logic [7:0] r;
      r = '0;
      for (int i = 0; i < 8; i++) if (x[i]) r = r ^ m[i];
      return r;
   endfunction

   // images of 1, b, b^2, ... where b is a tower root of the AES polynomial
   function automatic map_t build_fwd(input logic [1:0] n, input logic [3:0] l);
      map_t m;
      logic [7:0] beta, pw;
      beta = 8'h00;
      for (int c = 255; c >= 2; c--) begin
         logic [7:0] b1, b2, b4, b8, b3;
         b1 = 8'(c);
         b2 = tw_mul(b1, b1, n, l);
         b4 = tw_mul(b2, b2, n, l);
         b8 = tw_mul(b4, b4, n, l);
         b3 = tw_mul(b2, b1, n, l);
         if ((b8 ^ b4 ^ b3 ^ b1 ^ 8'h01) == 8'h00) beta = b1;
      end
      pw = 8'h01;
      for (int i = 0; i < 8; i++) begin
         m[i] = pw;
         pw = tw_mul(pw, beta, n, l);
      end
      return m;
   endfunction

   function automatic map_t build_inv(input map_t fwd);
      map_t m;
      m = '0;
      for (int j = 0; j < 8; j++)
         for (int e = 0; e < 256; e++)
            if (apply_map(fwd, 8'(e)) == (8'h01 << j)) m[j] = 8'(e);
      return m;
   endfunction

   function automatic logic [7:0] affine_lin(input logic [7:0] x);
      return x ^ {x[6:0], x[7]} ^ {x[5:0], x[7:6]} ^ {x[4:0], x[7:5]} ^ {x[3:0], x[7:4]};
   endfunction

   function automatic map_t build_merged(input map_t inv);
      map_t m;
      for (int j = 0; j < 8; j++) m[j] = affine_lin(inv[j]);
      return m;
   endfunction

endpackage

// File: rtl/tower_lin_map.sv
module tower_lin_map #(
   parameter aes_tower_pkg::map_t COLS = '0
) (
   input  logic [7:0] map_in,
   output logic [7:0] map_out
);
   for (genvar k = 0; k < 8; k++) begin : g_row
      logic [7:0] row;
      for (genvar i = 0; i < 8; i++) begin : g_col
         assign row[i] = COLS[i][k];
      end
      assign map_out[k] = ^(map_in & row);
   end
endmodule

// File: rtl/gf16_inverter.sv
module gf16_inverter
   import aes_tower_pkg::*;
#(
   parameter logic [1:0] N_SEL = 2'd2
) (
   input  logic [3:0] inv_in,
   output logic [3:0] inv_out
);
   logic [1:0] hi, lo, det, det_inv;

   assign hi      = inv_in[3:2];
   assign lo      = inv_in[1:0];
   assign det     = gf4_mul(gf4_sq(hi), N_SEL) ^ gf4_mul(hi, lo) ^ gf4_sq(lo);
   assign det_inv = gf4_sq(det);   // x^-1 = x^2 in the two-bit field
   assign inv_out = {gf4_mul(hi, det_inv), gf4_mul(hi ^ lo, det_inv)};

   always_comb begin
      AST_GF16_INV_PRODUCT: assert ((inv_in == 4'h0) ? (inv_out == 4'h0)
                                    : (gf16_mul(inv_in, inv_out, N_SEL) == 4'h1)); // R4
   end
endmodule

// File: rtl/gf256_inverter.sv
module gf256_inverter
   import aes_tower_pkg::*;
#(
   parameter logic [1:0] N_SEL = 2'd2,
   parameter logic [3:0] L_VAL = 4'h1
) (
   input  logic [7:0] tw_in,
   output logic [7:0] tw_out
);
   logic [3:0] hi, lo, det, det_inv;

   assign hi  = tw_in[7:4];
   assign lo  = tw_in[3:0];
   assign det = gf16_mul(gf16_mul(hi, hi, N_SEL), L_VAL, N_SEL)
              ^ gf16_mul(hi, lo, N_SEL) ^ gf16_mul(lo, lo, N_SEL);

   gf16_inverter #(.N_SEL(N_SEL)) u_sub_inv (.inv_in(det), .inv_out(det_inv));

   assign tw_out = {gf16_mul(hi, det_inv, N_SEL), gf16_mul(hi ^ lo, det_inv, N_SEL)};

   always_comb begin
      AST_GF256_INV_PRODUCT: assert ((tw_in == 8'h00) ? (tw_out == 8'h00)
                                     : (tw_mul(tw_in, tw_out, N_SEL, L_VAL) == 8'h01)); // R5
   end
endmodule

// File: rtl/aes_tower_sbox.sv
module aes_tower_sbox
   import aes_tower_pkg::*;
#(
   parameter logic [1:0] N_SEL        = 2'd2,
   parameter bit         MERGE_AFFINE = 1'b1
) (
   input  logic [7:0] sbox_in,
   output logic [7:0] sbox_out
);
   localparam logic [3:0] L_VAL   = find_ext_const(N_SEL);
   localparam map_t       FWD_MAP = build_fwd(N_SEL, L_VAL);
   localparam map_t       INV_MAP = build_inv(FWD_MAP);
   localparam map_t       MRG_MAP = build_merged(INV_MAP);
   localparam logic [7:0] AFF_C   = 8'h63;

   // R8: only the two constants with trace one are admissible
   if (!(N_SEL == 2'd2 || N_SEL == 2'd3)) begin : g_bad_n
      $error("aes_tower_sbox: N_SEL must be 2 or 3");
   end
   if (L_VAL == 4'h0) begin : g_bad_l
      $error("aes_tower_sbox: no irreducible byte extension found");
   end

   logic [7:0] tw_in, tw_inv;

   tower_lin_map #(.COLS(FWD_MAP)) u_to_tower (.map_in(sbox_in), .map_out(tw_in));

   gf256_inverter #(.N_SEL(N_SEL), .L_VAL(L_VAL)) u_inv (.tw_in(tw_in), .tw_out(tw_inv));

   if (MERGE_AFFINE) begin : g_fused
      logic [7:0] mapped;
      tower_lin_map #(.COLS(MRG_MAP)) u_back (.map_in(tw_inv), .map_out(mapped));
      assign sbox_out = mapped ^ AFF_C;
   end else begin : g_split
      logic [7:0] plain;
      tower_lin_map #(.COLS(INV_MAP)) u_back (.map_in(tw_inv), .map_out(plain));
      assign sbox_out = affine_lin(plain) ^ AFF_C;
   end

   always_comb begin
      if (sbox_in == 8'h00) begin
         AST_ZERO_GIVES_63: assert (sbox_out == 8'h63); // R2
      end
      AST_BASIS_ROUNDTRIP: assert (apply_map(INV_MAP, tw_in) == sbox_in); // R6
   end
endmodule

// File: tb/test_aes_tower_sbox.sv
`timescale 1ns/1ps
module test_aes_tower_sbox;
   typedef struct {
      logic [7:0] din;
      logic [7:0] exp;
      string      tag;
   } item_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [7:0] din = 8'h00;
   logic [7:0] dout_a, dout_b;
   int n_checks = 0;
   int n_fail   = 0;
   item_t q[$];
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   aes_tower_sbox i_aes_tower_sbox (.sbox_in(din), .sbox_out(dout_a));
   aes_tower_sbox #(.N_SEL(2'd3), .MERGE_AFFINE(1'b0)) i_aes_tower_sbox_alt
      (.sbox_in(din), .sbox_out(dout_b));

   function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] r, x;
      r = 8'h00; x = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) r = r ^ x;
         x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
      end
      return r;
   endfunction

   function automatic logic [7:0] ref_sbox(input logic [7:0] a);
      logic [7:0] inv, s;
      inv = 8'h01;
      for (int i = 0; i < 254; i++) inv = ref_mul(inv, a);
      if (a == 8'h00) inv = 8'h00;
      s = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]}
        ^ {inv[3:0], inv[7:4]} ^ 8'h63;
      return s;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [7:0] v, input logic [7:0] exp, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      din = v;
      it.din = v; it.exp = exp; it.tag = tag;
      q.push_back(it);
   endtask

   // monitor: output sampled mid-cycle, no clock edge since the input changed (R9)
   always @(negedge clk) begin
      if (!rst && q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         check($sformatf("%s in=%02h default", it.tag, it.din), dout_a, it.exp);
         check($sformatf("%s R7 R8 in=%02h alt", it.tag, it.din), dout_b, it.exp);
      end
   end

   initial begin
      #(200000 * 4);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reference sanity against known fixed points
      check("R2 ref 00", ref_sbox(8'h00), 8'h63);
      check("R3 ref 01", ref_sbox(8'h01), 8'h7C);
      check("R3 ref 53", ref_sbox(8'h53), 8'hED);
      drive(8'h00, 8'h63, "R2");
      drive(8'h01, 8'h7C, "R3");
      drive(8'h53, 8'hED, "R3");
      drive(8'hFF, 8'h16, "R1");
      for (int i = 0; i < 256; i++) drive(8'(i), ref_sbox(8'(i)), "R1 R4 R5 R6");
      for (int i = 0; i < 256; i++) begin
         logic [7:0] v;
         v = 8'(i * 8'h35 + 8'h11);
         drive(v, ref_sbox(v), "R9");
      end
      drive(8'h00, 8'h63, "R2 R9");
      drive(8'hFF, 8'h16, "R9");
      while (q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule